// File: doc/BRIEF.md
# Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division for a single-issue processor and holds the results in a HI/LO register pair. The issuing side hands over a start command in one cycle and moves on. The unit then works in the background and writes HI and LO only when the operation finishes. A `busy` flag marks the running operation. A `stall` output asks the pipeline to hold whenever it wants to read HI or LO before the result has landed.

A multiply takes 6, 9 or 13 cycles, chosen from the magnitude of the first operand. A divide always takes 36 cycles. Division by zero and the signed most-negative-by-minus-one case return fixed values and raise no exception. Direct writes to HI or LO take effect at once. Any new command cancels an operation that is still running.

Top module: `hilo_muldiv`

## Requirements
- R1: Command codes on `cmd_op` are 1 = signed multiply, 2 = unsigned multiply, 3 = signed divide, 4 = unsigned divide, 5 = write HI, 6 = write LO. A code of 1 to 4 sampled at a clock edge sets `busy` from that edge on. HI and LO do not change while `busy` is high.
- R2: After a start edge, `busy` stays high for exactly L cycles. HI and LO take the result at the same edge where `busy` falls.
- R3: An unsigned multiply has L = 6 when `opa` ≤ 0x7FF, L = 9 when `opa` ≤ 0xFFFFF, and L = 13 otherwise.
- R4: A signed multiply has L = 6 for `opa` in 0x0..0x7FF or 0xFFFFF800..0xFFFFFFFF. It has L = 9 for `opa` in 0x800..0xFFFFF or 0xFFF00000..0xFFFFF7FF. It has L = 13 otherwise.
- R5: Signed and unsigned divides have L = 36 for any operand values.
- R6: A multiply writes the 64-bit product of `opa` and `opb` into {HI, LO}, using signed or unsigned arithmetic as the code selects.
- R7: A divide writes the quotient to LO and the remainder to HI. Signed division truncates toward zero, and the remainder takes the sign of the dividend.
- R8: An unsigned divide by zero gives LO = 0xFFFFFFFF and HI = dividend.
- R9: A signed divide by zero gives HI = dividend. LO is 0xFFFFFFFF for a non-negative dividend and 0x00000001 for a negative one.
- R10: A signed divide of 0x80000000 by 0xFFFFFFFF gives HI = 0 and LO = 0x80000000.
- R11: Code 5 or 6 writes `opa` into HI or LO at the edge where it is sampled. If an operation is running, `busy` clears at that edge and the cancelled result is never written.
- R12: A start code that arrives while `busy` is high cancels the running operation. The new operation's latency is counted from its own start edge.
- R13: `stall` is high exactly when `rd_req` is high and `busy` is high. Codes 0 and 7 change neither HI, LO nor `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command code, 0 = none |
| opa | input | 32 | First operand / dividend / value for HI or LO write |
| opb | input | 32 | Second operand / divisor |
| rd_req | input | 1 | Pipeline wants to read HI or LO this cycle |
| busy | output | 1 | An operation is running |
| stall | output | 1 | Read request must wait |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |

## Verification
Every cycle, the assertions check four things:
- HI and LO hold steady while a countdown is in progress.
- `busy` rises after each start and falls at the final count.
- The iterative divider has finished before the counter releases its result.
- Direct HI/LO writes land at the next edge.

The bench's scenarios show the rest:
- the exact latency band chosen for each operand magnitude;
- the arithmetic values, including the zero-divisor and overflow results;
- that a cancelled result never appears later;
- the behaviour of the stall request at the ports.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    MD_NONE  = 3'd0,
    MD_MUL_S = 3'd1,
    MD_MUL_U = 3'd2,
    MD_DIV_S = 3'd3,
    MD_DIV_U = 3'd4,
    MD_SETHI = 3'd5,
    MD_SETLO = 3'd6,
    MD_RSVD  = 3'd7
  } md_op_e;

  function automatic logic op_is_mul(input logic [2:0] op);
    return (op == MD_MUL_S) || (op == MD_MUL_U);
  endfunction

  function automatic logic op_is_div(input logic [2:0] op);
    return (op == MD_DIV_S) || (op == MD_DIV_U);
  endfunction

  function automatic logic op_is_signed(input logic [2:0] op);
    return (op == MD_MUL_S) || (op == MD_DIV_S);
  endfunction
endpackage

// File: rtl/mdu_lat_sel.sv
module mdu_lat_sel #(
  parameter int W         = 32,
  parameter int FAST_BITS = 11,
  parameter int MED_BITS  = 20,
  parameter int LAT_FAST  = 6,
  parameter int LAT_MED   = 9,
  parameter int LAT_SLOW  = 13,
  parameter int LAT_DIV   = 36,
  parameter int CW        = 6
) (
  input  logic          is_div,
  input  logic          is_signed,
  input  logic [W-1:0]  a,
  output logic [CW-1:0] lat
);
  logic [W-1:0] mag;
  logic         fits_fast, fits_med;

  // a negative signed operand is banded by its one's complement
  always_comb begin
    mag       = (is_signed && a[W-1]) ? ~a : a;
    fits_fast = (mag >> FAST_BITS) == '0;
    fits_med  = (mag >> MED_BITS) == '0;
    if (is_div)         lat = CW'(LAT_DIV);
    else if (fits_fast) lat = CW'(LAT_FAST);
    else if (fits_med)  lat = CW'(LAT_MED);
    else                lat = CW'(LAT_SLOW);
  end
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  logic signed [W:0]     ea, eb;
  logic signed [2*W+1:0] full;
  logic [2*W-1:0]        prod_q;

  // one extra top bit turns both signednesses into one signed multiply
  always_comb begin
    ea   = $signed({sgn & a[W-1], a});
    eb   = $signed({sgn & b[W-1], b});
    full = ea * eb;
  end

  always_ff @(posedge clk) begin
    if (rst)        prod_q <= '0;
    else if (start) prod_q <= full[2*W-1:0];
  end

  assign prod = prod_q;
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rema,
  output logic         done
);
  localparam int SW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q, dvs_q;
  logic [SW-1:0] steps_q;
  logic          negq_q, negr_q, done_q;
  logic [W-1:0]  a_mag, b_mag;
  logic [W:0]    rem_sh;
  logic          ge;

  always_comb begin
    a_mag  = (sgn && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
    b_mag  = (sgn && divisor[W-1])  ? (~divisor + 1'b1)  : divisor;
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
  end

  // restoring division, one quotient bit per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      steps_q <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (start) begin
      rem_q   <= '0;
      quo_q   <= a_mag;
      dvs_q   <= b_mag;
      steps_q <= SW'(W);
      negq_q  <= sgn & (dividend[W-1] ^ divisor[W-1]);
      negr_q  <= sgn & dividend[W-1];
      done_q  <= 1'b0;
    end else if (steps_q != '0) begin
      rem_q   <= ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
      quo_q   <= {quo_q[W-2:0], ge};
      steps_q <= steps_q - 1'b1;
      if (steps_q == SW'(1)) done_q <= 1'b1;
    end
  end

  assign quot = negq_q ? (~quo_q + 1'b1) : quo_q;
  assign rema = negr_q ? (~rem_q[W-1:0] + 1'b1) : rem_q[W-1:0];
  assign done = done_q;

  AST_DIV_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (steps_q != '0) |-> !done_q); // R5
  AST_DIV_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> !done_q); // R12
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import muldiv_pkg::*;
#(
  parameter int W         = 32,
  parameter int FAST_BITS = 11,
  parameter int MED_BITS  = 20,
  parameter int LAT_FAST  = 6,
  parameter int LAT_MED   = 9,
  parameter int LAT_SLOW  = 13,
  parameter int LAT_DIV   = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         rd_req,
  output logic         busy,
  output logic         stall,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int LMAX = (LAT_DIV > LAT_SLOW) ? LAT_DIV : LAT_SLOW;
  localparam int CW   = $clog2(LMAX + 1);

  logic          start_mul, start_div, start_any, set_hi, set_lo, any_cmd;
  logic [CW-1:0] lat, cnt_q;
  logic          busy_q, kind_div_q;
  logic [W-1:0]  hi_q, lo_q, quot, rema;
  logic [2*W-1:0] prod;
  logic          div_done;

  always_comb begin
    start_mul = op_is_mul(cmd_op);
    start_div = op_is_div(cmd_op);
    start_any = start_mul | start_div;
    set_hi    = cmd_op == MD_SETHI;
    set_lo    = cmd_op == MD_SETLO;
    any_cmd   = start_any | set_hi | set_lo;
  end

  mdu_lat_sel #(
    .W(W), .FAST_BITS(FAST_BITS), .MED_BITS(MED_BITS),
    .LAT_FAST(LAT_FAST), .LAT_MED(LAT_MED), .LAT_SLOW(LAT_SLOW),
    .LAT_DIV(LAT_DIV), .CW(CW)
  ) u_lat (
    .is_div   (start_div),
    .is_signed(op_is_signed(cmd_op)),
    .a        (opa),
    .lat      (lat)
  );

  mdu_mul #(.W(W)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .start(start_mul),
    .sgn  (cmd_op == MD_MUL_S),
    .a    (opa),
    .b    (opb),
    .prod (prod)
  );

  mdu_div #(.W(W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start   (start_div),
    .sgn     (cmd_op == MD_DIV_S),
    .dividend(opa),
    .divisor (opb),
    .quot    (quot),
    .rema    (rema),
    .done    (div_done)
  );

  // latency counter: loaded with L at the start edge, result lands at count 1
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      kind_div_q <= 1'b0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else if (start_any) begin
      cnt_q      <= lat;
      busy_q     <= 1'b1;
      kind_div_q <= start_div;
    end else if (set_hi || set_lo) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      if (set_hi) hi_q <= opa;
      if (set_lo) lo_q <= opa;
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
        if (kind_div_q) begin
          hi_q <= rema;
          lo_q <= quot;
        end else begin
          hi_q <= prod[2*W-1:W];
          lo_q <= prod[W-1:0];
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy  = busy_q;
  assign stall = rd_req & busy_q;
  assign hi    = hi_q;
  assign lo    = lo_q;

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_any |=> busy_q); // R1
  AST_HOLD_WHILE_COUNTING: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q > CW'(1) && !any_cmd) |=> ($stable(hi_q) && $stable(lo_q))); // R1
  AST_BUSY_ENDS_AT_ONE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == CW'(1) && !any_cmd) |=> !busy_q); // R2
  AST_DIV_READY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && kind_div_q && cnt_q == CW'(1) && !any_cmd) |-> div_done); // R5
  AST_SETHI_NOW: assert property (@(posedge clk) disable iff (rst)
    set_hi |=> (hi_q == $past(opa) && !busy_q)); // R11
  AST_SETLO_NOW: assert property (@(posedge clk) disable iff (rst)
    set_lo |=> (lo_q == $past(opa) && !busy_q)); // R11
endmodule

// File: tb/test_hilo_muldiv.sv
`timescale 1ns/1ps
module test_hilo_muldiv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        rd_req = 1'b0;
  logic        busy, stall;
  logic [31:0] hi, lo;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  hilo_muldiv i_hilo_muldiv (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .opa(opa), .opb(opb),
    .rd_req(rd_req), .busy(busy), .stall(stall), .hi(hi), .lo(lo)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [2:0] op, input logic [31:0] a);
    logic [31:0] m;
    if (op == 3'd3 || op == 3'd4) return 36;
    m = (op == 3'd1 && a[31]) ? ~a : a;
    if (m <= 32'h7FF)   return 6;
    if (m <= 32'hFFFFF) return 9;
    return 13;
  endfunction

  function automatic logic [63:0] exp_res(input logic [2:0] op,
                                          input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    int q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      3'd1: return 64'(sa * sb);
      3'd2: return {32'd0, a} * {32'd0, b};
      3'd3: begin
        if (b == 0) return {a, (a[31] ? 32'h1 : 32'hFFFFFFFF)};
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return {32'h0, 32'h80000000};
        q = int'(sa / sb);
        r = int'(sa % sb);
        return {32'(r), 32'(q)};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R4 R6 signed mul";
      3'd2: return "R3 R6 unsigned mul";
      3'd3: return "R5 R7 signed div";
      default: return "R5 R7 unsigned div";
    endcase
  endfunction

  // issue a start, count busy cycles, then compare latency, hold and result
  task automatic run_op(input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
    logic [31:0] oh, ol;
    logic [63:0] e;
    int n;
    bit held;
    @(negedge clk);
    cmd_op = op; opa = a; opb = b;
    oh = hi; ol = lo;
    @(negedge clk);
    cmd_op = 3'd0;
    chk(busy === 1'b1, {tag, " R1 busy after start"}, 64'(busy), 64'd1);
    n = 0;
    held = 1'b1;
    while (busy === 1'b1 && n < 100) begin
      if (!(op == 3'd0) && n > 0 && (hi !== oh || lo !== ol)) held = 1'b0;
      n++;
      @(negedge clk);
    end
    e = exp_res(op, a, b);
    chk(n == exp_lat(op, a), {tag, " R2 latency"}, 64'(n), 64'(exp_lat(op, a)));
    chk(held, {tag, " R1 hold while busy"}, 64'(held), 64'd1);
    chk({hi, lo} === e, {tag, " result"}, {hi, lo}, e);
  endtask

  function automatic logic [31:0] rnd_a();
    logic [31:0] v;
    v = $urandom;
    case ($urandom % 6)
      0: return v & 32'h7FF;
      1: return 32'h800 + (v & 32'hF7FFF);
      2: return v | 32'hFFFFF800;
      3: return 32'hFFF00000 | (v & 32'hFF7FF);
      4: return v;
      default: return {1'b1, v[30:0]};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && hi === 32'd0 && lo === 32'd0, "reset state",
        {31'd0, busy, hi}, 64'd0);

    // latency band edges, unsigned R3 and signed R4
    run_op(3'd2, 32'h000007FF, 32'h12345678, "R3 u fast edge");
    run_op(3'd2, 32'h00000800, 32'h12345678, "R3 u med low");
    run_op(3'd2, 32'h000FFFFF, 32'hFFFFFFFF, "R3 u med edge");
    run_op(3'd2, 32'h00100000, 32'hFFFFFFFF, "R3 u slow");
    run_op(3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3 u max");
    run_op(3'd1, 32'hFFFFF800, 32'h00000003, "R4 s fast neg edge");
    run_op(3'd1, 32'hFFFFF7FF, 32'h80000000, "R4 s med neg");
    run_op(3'd1, 32'hFFF00000, 32'h7FFFFFFF, "R4 s med neg edge");
    run_op(3'd1, 32'hFFEFFFFF, 32'h00000002, "R4 s slow neg");
    run_op(3'd1, 32'h80000000, 32'h80000000, "R4 s min");
    run_op(3'd1, 32'h000FFFFF, 32'hFFFFFFFF, "R4 s med pos");
    // divide corners
    run_op(3'd4, 32'hDEADBEEF, 32'd0, "R8 udiv by zero");
    run_op(3'd3, 32'h12345678, 32'd0, "R9 sdiv zero pos");
    run_op(3'd3, 32'hF0000001, 32'd0, "R9 sdiv zero neg");
    run_op(3'd3, 32'h80000000, 32'hFFFFFFFF, "R10 sdiv overflow");
    run_op(3'd3, 32'hFFFFFFF9, 32'd2, "R7 sdiv neg/pos");
    run_op(3'd3, 32'd7, 32'hFFFFFFFE, "R7 sdiv pos/neg");
    run_op(3'd4, 32'hFFFFFFFF, 32'd1, "R7 udiv by one");

    // stall follows read request only while busy: R13
    @(negedge clk);
    cmd_op = 3'd4; opa = 32'd1000; opb = 32'd7;
    @(negedge clk);
    cmd_op = 3'd0; rd_req = 1'b1;
    #0.1;
    chk(stall === 1'b1, "R13 stall while busy", 64'(stall), 64'd1);
    @(negedge clk);
    rd_req = 1'b0;
    #0.1;
    chk(stall === 1'b0, "R13 no stall without request", 64'(stall), 64'd0);
    repeat (40) @(negedge clk);
    rd_req = 1'b1;
    #0.1;
    chk(stall === 1'b0 && lo === 32'd142 && hi === 32'd6, "R13 no stall when idle",
        {31'd0, stall, lo}, {32'd0, 32'd142});
    rd_req = 1'b0;

    // codes 0 and 7 do nothing: R13
    @(negedge clk);
    cmd_op = 3'd7; opa = 32'hAAAA5555; opb = 32'h1;
    @(negedge clk);
    cmd_op = 3'd0;
    chk(busy === 1'b0 && hi === 32'd6 && lo === 32'd142, "R13 code 7 ignored",
        {31'd0, busy, hi}, {32'd0, 32'd6});

    // direct write aborts a running divide: R11
    @(negedge clk);
    cmd_op = 3'd3; opa = 32'd99; opb = 32'd10;
    @(negedge clk);
    cmd_op = 3'd0;
    repeat (4) @(negedge clk);
    cmd_op = 3'd5; opa = 32'hCAFEF00D;
    @(negedge clk);
    cmd_op = 3'd0;
    chk(busy === 1'b0 && hi === 32'hCAFEF00D, "R11 write HI aborts",
        {31'd0, busy, hi}, {32'd0, 32'hCAFEF00D});
    repeat (40) @(negedge clk);
    chk(hi === 32'hCAFEF00D && lo === 32'd142, "R11 aborted result dropped",
        {hi, lo}, {32'hCAFEF00D, 32'd142});
    @(negedge clk);
    cmd_op = 3'd6; opa = 32'h0BADC0DE;
    @(negedge clk);
    cmd_op = 3'd0;
    chk(lo === 32'h0BADC0DE && hi === 32'hCAFEF00D, "R11 write LO",
        {hi, lo}, {32'hCAFEF00D, 32'h0BADC0DE});

    // restart while busy: R12
    @(negedge clk);
    cmd_op = 3'd4; opa = 32'd5000; opb = 32'd3;
    @(negedge clk);
    cmd_op = 3'd0;
    repeat (3) @(negedge clk);
    run_op(3'd2, 32'd300, 32'd7, "R12 restart mul");
    repeat (40) @(negedge clk);
    chk({hi, lo} === 64'd2100, "R12 old divide never lands", {hi, lo}, 64'd2100);

    // random mix
    for (int i = 0; i < 250; i++) begin
      logic [2:0] op;
      logic [31:0] a, b;
      op = 3'(1 + ($urandom % 4));
      a = rnd_a();
      b = ($urandom % 10 == 0) ? 32'd0 : (($urandom % 2) ? $urandom : ($urandom & 32'hFFFF));
      run_op(op, a, b, op_tag(op));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule